// File: doc/BRIEF.md
# ATM Cell Insertion Buffer

This block sits on the transmit side of a cell stream and lets a host processor inject its own ATM cells. The processor writes a cell byte by byte through a four-address register port. It flags the first byte of each cell by setting a marker bit in the control register before writing that byte. The block holds up to four cells. Once a cell is complete and the transmit path offers an insertion slot, the block sends that cell as one unbroken burst.

Software learns whether another whole cell fits either by polling a room flag or by taking an interrupt that fires every time a buffered cell leaves. After power-up the buffer refuses data until software writes its clear bit once. Two control bits belong to the receive side and are only stored here.

The writer state machine has two states. `W_IDLE` means no cell is open. `W_FILL` means a cell is being written. Its transitions are: open (`W_IDLE` to `W_FILL` on a marked byte when a slot is free), restart (`W_FILL` to `W_FILL` on a marked byte, which rewinds the same slot), commit (`W_FILL` to `W_IDLE` on the last byte) and clear (any state to `W_IDLE` on a buffer clear).

The sender state machine also has two states, `R_IDLE` and `R_SEND`. Its transitions are: launch (`R_IDLE` to `R_SEND` when a slot is requested and a whole cell is stored), finish (`R_SEND` to `R_IDLE` after the last byte) and abort (any state to `R_IDLE` on a buffer clear).

Top module: `cell_insert_buf`

## Requirements
- R1: After `rst_n` the control register (address 0) reads 0x10, the interrupt register (address 2) reads 0x00, and `irq` and `tx_valid` are low.
- R2: Until a 1 is written to control bit 2, the room flag (control bit 1) reads 0 and every data byte is dropped. Control bit 2 always reads 0.
- R3: The room flag reads 1 when the buffer is armed and the stored cells plus any cell being written number fewer than four.
- R4: Control bit 0 marks the next data byte (address 1) as byte 0 of a new cell. The data write clears bit 0. A marked byte during an open cell discards the partial cell and restarts it in the same slot.
- R5: A data byte that is not stored sets sticky bit 2 of the interrupt register. This covers three cases: the buffer is not armed, no cell is open, or a marked byte arrives with four cells stored.
- R6: A cell is never sent before all 53 of its bytes have been written.
- R7: When `slot_req` is high in an idle cycle and a whole cell is stored, the next cycle starts 53 consecutive `tx_valid` cycles. `tx_soc` is high on the first of them, and the bytes come out in write order. Cells leave in the order they were completed.
- R8: Bit 1 of the interrupt register is set by the clock edge that ends a cell's burst. Reading address 2 clears it and bit 2. If a set and a read fall on the same edge, the set wins.
- R9: `irq` equals interrupt bit 1 ANDed with enable bit 0 of the interrupt register.
- R10: Writing 1 to control bit 2 empties the buffer, aborts any burst so that `tx_valid` is low the next cycle, and leaves the room flag at 1.
- R11: Control bits 3 and 4 are read/write bits with reset values 0 and 1 and no effect on the buffer. Control bits 7 to 5 and addresses 1 and 3 read 0.
- R12: A cell commit and a cell drain on the same edge leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 interrupt |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Cell-sent interrupt |
| slot_req | input | 1 | Transmit path offers an insertion slot |
| tx_valid | output | 1 | Output byte valid |
| tx_soc | output | 1 | First byte of a cell |
| tx_data | output | 8 | Output byte |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the writer committing a cell's last byte while the sender retires the final byte of another cell. The bench provokes this by holding the 53rd byte back and writing it exactly when the running burst reaches byte 52. It then judges the stored count by checking that the room flag still drops only when the fourth cell opens. The second pair is a read of the interrupt register on the very edge that ends a burst. That read must return the old value, and a second read must still show the sent bit.

// File: rtl/cib_pkg.sv
package cib_pkg;
    typedef enum logic {W_IDLE, W_FILL} wr_state_t;
    typedef enum logic {R_IDLE, R_SEND} rd_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_IRQ  = 2'd2;
endpackage

// File: rtl/cib_regs.sv
module cib_regs
    import cib_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          room,
    input  logic          drop_pulse,
    input  logic          sent_pulse,
    output logic          ins_clr,
    output logic          byte_wr,
    output logic [DW-1:0] byte_data,
    output logic          soc_mark
);
    logic soc_pend, ext_clav, ext_rst, irq_en, sent_flag, drop_flag;
    logic ctrl_wr, irq_rd;
    logic [DW-1:0] rd_mux;

    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign byte_wr   = reg_wr && (reg_addr == A_DATA);
    assign irq_rd    = reg_rd && (reg_addr == A_IRQ);
    assign ins_clr   = ctrl_wr && reg_wdata[2];
    assign byte_data = reg_wdata;
    assign soc_mark  = soc_pend;
    assign irq       = sent_flag && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soc_pend  <= 1'b0;
            ext_clav  <= 1'b0;
            ext_rst   <= 1'b1;
            irq_en    <= 1'b0;
            sent_flag <= 1'b0;
            drop_flag <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                soc_pend <= reg_wdata[0];
                ext_clav <= reg_wdata[3];
                ext_rst  <= reg_wdata[4];
            end else if (byte_wr) begin
                soc_pend <= 1'b0;
            end
            if (reg_wr && reg_addr == A_IRQ)
                irq_en <= reg_wdata[0];
            if (sent_pulse)
                sent_flag <= 1'b1;
            else if (irq_rd)
                sent_flag <= 1'b0;
            if (drop_pulse)
                drop_flag <= 1'b1;
            else if (irq_rd)
                drop_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            A_CTRL:  rd_mux[4:0] = {ext_rst, ext_clav, 1'b0, room, soc_pend};
            A_IRQ:   rd_mux[2:0] = {drop_flag, sent_flag, irq_en};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
    p_sent_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sent_pulse |=> sent_flag);
    p_drop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> drop_flag);
endmodule

// File: rtl/cib_wr.sv
module cib_wr
    import cib_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 4,
    localparam int CNT_W     = $clog2(CELL_BYTES),
    localparam int PTR_W     = $clog2(CELLS),
    localparam int OCC_W     = $clog2(CELLS + 1),
    localparam int AW        = $clog2(CELLS * CELL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_clr,
    input  logic          byte_wr,
    input  logic [DW-1:0] byte_data,
    input  logic          soc_mark,
    input  logic          drain,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          room,
    output logic          avail,
    output logic          drop
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

    logic [DW-1:0]    mem [CELLS*CELL_BYTES];
    wr_state_t        wstate, wstate_nx;
    logic [CNT_W-1:0] wcnt;
    logic [PTR_W-1:0] wslot;
    logic [OCC_W-1:0] stored;
    logic             armed, start, cont, accept, commit;
    logic [CNT_W-1:0] widx;
    logic [AW-1:0]    waddr;

    assign start  = byte_wr && armed && soc_mark &&
                    (wstate == W_FILL || stored < OCC_W'(CELLS));
    assign cont   = byte_wr && armed && !soc_mark && wstate == W_FILL;
    assign accept = start || cont;
    assign drop   = byte_wr && !accept;
    assign commit = cont && wcnt == LAST;
    assign widx   = start ? '0 : wcnt;
    assign waddr  = AW'(wslot) * AW'(CELL_BYTES) + AW'(widx);
    assign room   = armed &&
                    ((stored + OCC_W'(wstate == W_FILL)) < OCC_W'(CELLS));
    assign avail  = stored != '0;
    assign rd_data = mem[rd_addr];

    always_comb begin
        wstate_nx = wstate;
        unique case (wstate)
            W_IDLE: if (start)  wstate_nx = W_FILL;
            W_FILL: if (commit) wstate_nx = W_IDLE;
        endcase
        if (ins_clr) wstate_nx = W_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wstate <= W_IDLE;
        else        wstate <= wstate_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            wcnt   <= '0;
            wslot  <= '0;
            stored <= '0;
        end else if (ins_clr) begin
            armed  <= 1'b1;
            wcnt   <= '0;
            wslot  <= '0;
            stored <= '0;
        end else begin
            if (start)
                wcnt <= CNT_W'(1);
            else if (cont)
                wcnt <= commit ? '0 : wcnt + 1'b1;
            if (commit)
                wslot <= (wslot == PTR_W'(CELLS - 1)) ? '0 : wslot + 1'b1;
            unique case ({commit, drain})
                2'b10:   stored <= stored + 1'b1;
                2'b01:   stored <= stored - 1'b1;
                default: stored <= stored;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[waddr] <= byte_data;
    end

    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stored <= OCC_W'(CELLS));
    p_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (stored == '0 && !room));
    p_both_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && drain && !ins_clr) |=> stored == $past(stored));
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_clr |=> (stored == '0 && wstate == W_IDLE && room));
endmodule

// File: rtl/cib_rd.sv
module cib_rd
    import cib_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 4,
    localparam int CNT_W     = $clog2(CELL_BYTES),
    localparam int PTR_W     = $clog2(CELLS),
    localparam int AW        = $clog2(CELLS * CELL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_clr,
    input  logic          slot_req,
    input  logic          avail,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          drain,
    output logic          tx_valid,
    output logic          tx_soc,
    output logic [DW-1:0] tx_data
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

    rd_state_t        rstate, rstate_nx;
    logic [CNT_W-1:0] rcnt;
    logic [PTR_W-1:0] rslot;

    always_comb begin
        rstate_nx = rstate;
        unique case (rstate)
            R_IDLE: if (slot_req && avail) rstate_nx = R_SEND;
            R_SEND: if (rcnt == LAST)      rstate_nx = R_IDLE;
        endcase
        if (ins_clr) rstate_nx = R_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rstate <= R_IDLE;
        else        rstate <= rstate_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt  <= '0;
            rslot <= '0;
        end else if (ins_clr) begin
            rcnt  <= '0;
            rslot <= '0;
        end else if (rstate == R_SEND) begin
            rcnt <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
            if (rcnt == LAST)
                rslot <= (rslot == PTR_W'(CELLS - 1)) ? '0 : rslot + 1'b1;
        end
    end

    always_comb begin
        rd_addr  = AW'(rslot) * AW'(CELL_BYTES) + AW'(rcnt);
        tx_valid = rstate == R_SEND;
        drain    = tx_valid && rcnt == LAST;
        tx_soc   = tx_valid && rcnt == '0;
        tx_data  = tx_valid ? rd_data : '0;
    end

    p_lead_soc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_soc);
    p_unbroken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !drain && !ins_clr) |=> tx_valid);
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_clr |=> !tx_valid);
endmodule

// File: rtl/cell_insert_buf.sv
module cell_insert_buf
    import cib_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 4,
    localparam int AW        = $clog2(CELLS * CELL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          slot_req,
    output logic          tx_valid,
    output logic          tx_soc,
    output logic [DW-1:0] tx_data
);
    logic          room, drop, drain, ins_clr, byte_wr, soc_mark, avail;
    logic [DW-1:0] byte_data, rd_data;
    logic [AW-1:0] rd_addr;

    cib_regs #(.DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .room(room), .drop_pulse(drop), .sent_pulse(drain),
        .ins_clr(ins_clr), .byte_wr(byte_wr), .byte_data(byte_data),
        .soc_mark(soc_mark)
    );

    cib_wr #(.DW(DW), .CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) i_wr (
        .clk(clk), .rst_n(rst_n), .ins_clr(ins_clr), .byte_wr(byte_wr),
        .byte_data(byte_data), .soc_mark(soc_mark), .drain(drain),
        .rd_addr(rd_addr), .rd_data(rd_data), .room(room), .avail(avail),
        .drop(drop)
    );

    cib_rd #(.DW(DW), .CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) i_rd (
        .clk(clk), .rst_n(rst_n), .ins_clr(ins_clr), .slot_req(slot_req),
        .avail(avail), .rd_data(rd_data), .rd_addr(rd_addr), .drain(drain),
        .tx_valid(tx_valid), .tx_soc(tx_soc), .tx_data(tx_data)
    );
endmodule

// File: tb/test_cell_insert_buf.sv
module test_cell_insert_buf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, slot_req, tx_valid, tx_soc;
    logic [7:0] tx_data;
    logic       slot_dir = 1'b0, slot_rand = 1'b0, rand_mode = 1'b0;

    int n_chk = 0, n_fail = 0, mpos = 0;
    bit mon_on = 1'b1, ended = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] cur[53];

    assign slot_req = rand_mode ? slot_rand : slot_dir;

    always #2.5 clk = ~clk;

    cell_insert_buf i_cell_insert_buf (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .slot_req(slot_req), .tx_valid(tx_valid),
        .tx_soc(tx_soc), .tx_data(tx_data)
    );

    function automatic logic [7:0] exp_ctrl(bit rm, bit soc, bit clav, bit erst);
        return {3'b000, erst, clav, 1'b0, rm, soc};
    endfunction

    function automatic logic [7:0] exp_irqreg(bit en, bit sent, bit drp);
        return {5'b00000, drp, sent, en};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic fill_cell();
        for (int i = 0; i < 53; i++) cur[i] = 8'($urandom);
    endtask

    task automatic put_bytes(input int from, input int to);
        for (int i = from; i < to; i++) begin
            if (i == 0) bus_write(2'd0, 8'h11);
            bus_write(2'd1, cur[i]);
        end
    endtask

    task automatic push_cell();
        for (int i = 0; i < 53; i++) exp_q.push_back(cur[i]);
    endtask

    task automatic full_cell();
        fill_cell();
        put_bytes(0, 53);
        push_cell();
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(negedge clk) slot_rand <= ($urandom % 3) != 0;

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (tx_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 byte sent with no complete cell", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e, "R7 data order", tx_data, e);
                    chk(tx_soc == (mpos == 0), "R7 soc flag", tx_soc, mpos == 0);
                end
                mpos = (mpos == 52) ? 0 : mpos + 1;
            end else if (mpos != 0) begin
                chk(1'b0, "R7 gap inside cell", mpos, 0);
                mpos = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);

        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        bus_read(2'd0, d); chk(d == exp_ctrl(0, 0, 0, 1), "R1 ctrl reset", d, exp_ctrl(0, 0, 0, 1));
        bus_read(2'd2, d); chk(d == exp_irqreg(0, 0, 0), "R1 irq reg reset", d, 0);

        // R2: not armed, byte dropped; R4 marker cleared by data write
        bus_write(2'd0, 8'h11);
        bus_write(2'd1, 8'hAA);
        bus_read(2'd0, d); chk(d == exp_ctrl(0, 0, 0, 1), "R2 room low before arm / R4 marker cleared", d, exp_ctrl(0, 0, 0, 1));
        bus_read(2'd2, d); chk(d == exp_irqreg(0, 0, 1), "R5 drop when unarmed", d, exp_irqreg(0, 0, 1));
        bus_read(2'd2, d); chk(d == exp_irqreg(0, 0, 0), "R8 read clears drop", d, 0);
        bus_write(2'd0, 8'h14);
        bus_read(2'd0, d); chk(d == exp_ctrl(1, 0, 0, 1), "R2 armed, bit2 reads 0", d, exp_ctrl(1, 0, 0, 1));

        // R11 placeholder bits
        bus_write(2'd0, 8'hE8);
        bus_read(2'd0, d); chk(d == exp_ctrl(1, 0, 1, 0), "R11 bits 3/4 rw, 7:5 zero", d, exp_ctrl(1, 0, 1, 0));
        bus_write(2'd0, 8'h10);
        bus_read(2'd0, d); chk(d == exp_ctrl(1, 0, 0, 1), "R11 restore", d, exp_ctrl(1, 0, 0, 1));
        bus_read(2'd1, d); chk(d == 8'h00, "R11 data addr reads 0", d, 0);
        bus_read(2'd3, d); chk(d == 8'h00, "R11 addr 3 reads 0", d, 0);

        // R6: 52 bytes must not be sent
        bus_write(2'd2, 8'h01);
        slot_dir = 1'b1;
        fill_cell();
        put_bytes(0, 52);
        wait_n(10);
        chk(tx_valid == 1'b0, "R6 partial cell held", tx_valid, 0);
        bus_write(2'd1, cur[52]);
        push_cell();
        wait_n(60);
        chk(exp_q.size() == 0, "R7 cell delivered", exp_q.size(), 0);
        chk(irq == 1'b1, "R9 irq raised when enabled", irq, 1);
        bus_read(2'd2, d); chk(d == exp_irqreg(1, 1, 0), "R8 sent status", d, exp_irqreg(1, 1, 0));
        chk(irq == 1'b0, "R8 read clears irq", irq, 0);

        // R4 restart
        slot_dir = 1'b0;
        fill_cell();
        put_bytes(0, 10);
        full_cell();
        slot_dir = 1'b1;
        wait_n(60);
        chk(exp_q.size() == 0, "R4 restarted cell only", exp_q.size(), 0);
        bus_read(2'd2, d);

        // R3 / R5 fill to capacity
        slot_dir = 1'b0;
        repeat (3) full_cell();
        bus_read(2'd0, d); chk(d[1] == 1'b1, "R3 room with three cells", d[1], 1);
        fill_cell();
        put_bytes(0, 1);
        bus_read(2'd0, d); chk(d[1] == 1'b0, "R3 room low with four slots used", d[1], 0);
        put_bytes(1, 53);
        push_cell();
        fill_cell();
        put_bytes(0, 1);
        bus_read(2'd2, d); chk(d[2] == 1'b1, "R5 drop when full", d[2], 1);
        bus_write(2'd2, 8'h00);
        slot_dir = 1'b1;
        wait_n(240);
        chk(exp_q.size() == 0, "R7 four cells in order", exp_q.size(), 0);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        bus_read(2'd2, d); chk(d == exp_irqreg(0, 1, 0), "R9 status set while masked", d, exp_irqreg(0, 1, 0));

        // R8 set wins over read clear
        slot_dir = 1'b0;
        full_cell();
        slot_dir = 1'b1;
        wait_n(53);
        bus_read(2'd2, d); chk(d == exp_irqreg(0, 0, 0), "R8 read on drain edge returns old", d, 0);
        bus_read(2'd2, d); chk(d == exp_irqreg(0, 1, 0), "R8 set wins same edge", d, exp_irqreg(0, 1, 0));

        // R12 commit and drain on the same edge
        slot_dir = 1'b0;
        full_cell();
        fill_cell();
        put_bytes(0, 52);
        slot_dir = 1'b1;
        wait_n(53);
        bus_write(2'd1, cur[52]);
        push_cell();
        wait_n(70);
        chk(exp_q.size() == 0, "R12 both cells delivered", exp_q.size(), 0);
        slot_dir = 1'b0;
        repeat (3) full_cell();
        bus_read(2'd0, d); chk(d[1] == 1'b1, "R12 count consistent (3)", d[1], 1);
        fill_cell();
        put_bytes(0, 1);
        bus_read(2'd0, d); chk(d[1] == 1'b0, "R12 count consistent (4)", d[1], 0);
        put_bytes(1, 53);
        push_cell();
        slot_dir = 1'b1;
        wait_n(240);
        chk(exp_q.size() == 0, "R12 drained", exp_q.size(), 0);

        // R10 clear during burst
        slot_dir = 1'b0;
        repeat (2) full_cell();
        slot_dir = 1'b1;
        wait_n(20);
        mon_on = 1'b0;
        bus_write(2'd0, 8'h14);
        chk(tx_valid == 1'b0, "R10 burst aborted", tx_valid, 0);
        exp_q.delete();
        mpos = 0;
        mon_on = 1'b1;
        wait_n(80);
        chk(tx_valid == 1'b0, "R10 buffer empty", tx_valid, 0);
        bus_read(2'd0, d); chk(d == exp_ctrl(1, 0, 0, 1), "R10 room after clear", d, exp_ctrl(1, 0, 0, 1));

        // random phase
        rand_mode = 1'b1;
        for (int c = 0; c < 24; c++) begin
            int tries = 0;
            do begin
                bus_read(2'd0, d);
                tries++;
            end while (!d[1] && tries < 1000);
            if ($urandom % 4 == 0) begin
                fill_cell();
                put_bytes(0, 1 + int'($urandom % 40));
            end
            full_cell();
        end
        for (int w = 0; w < 3000 && exp_q.size() != 0; w++) @(negedge clk);
        wait_n(60);
        chk(exp_q.size() == 0, "R7 random traffic delivered", exp_q.size(), 0);
        summary();
    end
endmodule